// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Manager

This block sits on the controller side of an SDRAM interface. It keeps the device's rows alive in two ways. In normal operation a free-running interval timer raises one AUTO REFRESH request per interval. The default interval is the refresh period divided by the 4096 refreshes the device needs in each period. Requests that the command arbiter has not yet granted are kept in a saturating backlog. The block also drives the clock-enable pin and runs the self-refresh sequence. Entry issues SELF REFRESH with CKE low. The block then holds the device in self refresh for a minimum dwell time. On exit it raises CKE only when the clock is reported stable. It then claims the command bus for a run of NOPs covering the exit recovery time. It finishes with a forced catch-up AUTO REFRESH, because self refresh and auto refresh share the device's internal row counter.

Commands leave the block on a valid/ready stream towards the arbiter. `cmd_valid` together with `cmd_op` offers one command. A transfer takes place on a rising edge where `cmd_valid` and `cmd_ready` are both high. Back-pressure is allowed at any time. While `cmd_ready` is low, the offered command stays asserted and unchanged. The request inputs and `clk_stable` are plain levels, sampled on every clock.

Top module: `sdr_refresh_mgr`

## Requirements
- R1: While `rst_n` is low, `cke` is high and `cmd_valid` is low.
- R2: After reset release, or after a refresh timer restart, an AUTO REFRESH request (`cmd_op` = 1) is added on every REF_INTERVAL-th rising edge seen in normal operation. The first request becomes visible after the REF_INTERVAL-th edge.
- R3: Ungranted AUTO REFRESH requests accumulate up to BACKLOG_MAX; further timer events are dropped while the backlog is full. Each granted AUTO REFRESH removes exactly one.
- R4: Once `cmd_valid` is high it stays high with the same `cmd_op` until a rising edge with `cmd_ready` high.
- R5: `sr_enter_req` starts entry only in normal operation with an empty backlog. Until then, pending AUTO REFRESH requests are served first and `cke` stays high.
- R6: Entry offers SELF REFRESH (`cmd_op` = 2) with `cke` already low. `cke` stays low from that offer until the exit sequence begins.
- R7: After the edge that grants SELF REFRESH, `cke` stays low for at least T_RAS+1 sampled cycles. An exit request made during that dwell has no effect on the dwell.
- R8: Exit starts only on an edge where both `sr_exit_req` and `clk_stable` are high after the dwell. `cke` rises on that edge.
- R9: Once `cke` is high again, the block offers only NOP (`cmd_op` = 0) until exactly max(T_XSR, 2) NOPs have been granted.
- R10: Right after the last recovery NOP is granted, the block offers an AUTO REFRESH with a backlog of exactly one, and the interval timer restarts.
- R11: `sr_exit_req` has no effect on `cke` in normal operation. `sr_enter_req` does not produce another SELF REFRESH while the device is already in self refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | output | 1 | A command is offered to the arbiter |
| cmd_ready | input | 1 | Arbiter grants the offered command on this edge |
| cmd_op | output | 2 | Offered command: 0 NOP, 1 AUTO REFRESH, 2 SELF REFRESH |
| cke | output | 1 | Clock enable to the SDRAM |
| sr_enter_req | input | 1 | Level request to enter self refresh |
| sr_exit_req | input | 1 | Level request to leave self refresh |
| clk_stable | input | 1 | The device clock is within its limits |

## Verification
The bench holds off grants long enough to overflow the backlog, then counts the refreshes that drain. A backlog without saturation would drain too many, and a wrapping counter would drain too few. It asks for entry while a refresh is still waiting, and asks for exit early during the dwell. A design that cut the queue or the dwell short would show SELF REFRESH or a CKE rise too early. It keeps `clk_stable` low with an exit requested, throttles the recovery NOPs with a random grant, and then expects an AUTO REFRESH at once. A design that counted cycles instead of granted NOPs, ignored the clock check, or skipped the catch-up refresh would give the wrong NOP count or the wrong command.

// File: rtl/srm_pkg.sv
package srm_pkg;

  // Command codes offered to the arbiter; the arbiter decodes these values.
  typedef enum logic [1:0] {
    SRM_OP_NOP  = 2'd0,
    SRM_OP_AREF = 2'd1,
    SRM_OP_SREF = 2'd2
  } srm_op_e;

  typedef enum logic [2:0] {
    ST_RUN,        // normal operation, distributed refresh
    ST_SR_ISSUE,   // SELF REFRESH offered, CKE low
    ST_SR_DWELL,   // minimum residency in self refresh
    ST_SR_HOLD,    // in self refresh, waiting for exit conditions
    ST_SR_RECOVER  // CKE high, NOP-only recovery window
  } srm_state_e;

endpackage

// File: rtl/srm_interval_timer.sv
module srm_interval_timer #(
  parameter int unsigned INTERVAL = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned IW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [IW-1:0] LAST = IW'(INTERVAL - 1);

  logic [IW-1:0] cnt;

  // The count restarts from zero whenever the timer is parked.
  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                 cnt <= cnt + IW'(1);
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/srm_backlog.sv
module srm_backlog #(
  parameter  int unsigned MAX = 8,
  localparam int unsigned W   = $clog2(MAX + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         dec,
  input  logic         clear,
  input  logic         preset_one,
  output logic [W-1:0] count,
  output logic         nonzero
);
  localparam logic [W-1:0] FULL = W'(MAX);

  logic [W-1:0] c_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          c_q <= '0;
    else if (clear)      c_q <= '0;
    else if (preset_one) c_q <= W'(1);
    else if (inc && !dec) begin
      if (c_q != FULL) c_q <= c_q + W'(1);
    end else if (dec && !inc) begin
      if (c_q != '0) c_q <= c_q - W'(1);
    end
  end

  assign count   = c_q;
  assign nonzero = (c_q != '0);
endmodule

// File: rtl/srm_sr_fsm.sv
module srm_sr_fsm
  import srm_pkg::*;
#(
  parameter int unsigned T_RAS = 5,
  parameter int unsigned T_XSR = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enter_req,
  input  logic       exit_req,
  input  logic       clk_stable,
  input  logic       backlog_empty,
  input  logic       hs,
  output srm_state_e state,
  output logic       cke,
  output logic       sref_taken,
  output logic       recover_done
);
  localparam int unsigned RAS_EFF = (T_RAS < 1) ? 1 : T_RAS;
  localparam int unsigned XSR_EFF = (T_XSR < 2) ? 2 : T_XSR;
  localparam int unsigned SPAN    = (RAS_EFF > XSR_EFF) ? RAS_EFF : XSR_EFF;
  localparam int unsigned CW      = $clog2(SPAN + 1);

  srm_state_e    st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_RUN;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_RUN: begin
          if (enter_req && backlog_empty) st_q <= ST_SR_ISSUE;
        end
        ST_SR_ISSUE: begin
          if (hs) begin
            st_q  <= ST_SR_DWELL;
            cnt_q <= CW'(RAS_EFF - 1);
          end
        end
        ST_SR_DWELL: begin
          if (cnt_q == '0) st_q  <= ST_SR_HOLD;
          else             cnt_q <= cnt_q - CW'(1);
        end
        ST_SR_HOLD: begin
          if (exit_req && clk_stable) begin
            st_q  <= ST_SR_RECOVER;
            cnt_q <= CW'(XSR_EFF - 1);
          end
        end
        ST_SR_RECOVER: begin
          if (hs) begin
            if (cnt_q == '0) st_q  <= ST_RUN;
            else             cnt_q <= cnt_q - CW'(1);
          end
        end
        default: st_q <= ST_RUN;
      endcase
    end
  end

  assign state        = st_q;
  assign cke          = !(st_q == ST_SR_ISSUE || st_q == ST_SR_DWELL || st_q == ST_SR_HOLD);
  assign sref_taken   = (st_q == ST_SR_ISSUE) && hs;
  assign recover_done = (st_q == ST_SR_RECOVER) && hs && (cnt_q == '0);
endmodule

// File: rtl/sdr_refresh_mgr.sv
module sdr_refresh_mgr
  import srm_pkg::*;
#(
  parameter int unsigned REF_INTERVAL = 1560,
  parameter int unsigned T_RAS        = 5,
  parameter int unsigned T_XSR        = 8,
  parameter int unsigned BACKLOG_MAX  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic       cmd_valid,
  input  logic       cmd_ready,
  output logic [1:0] cmd_op,
  output logic       cke,
  input  logic       sr_enter_req,
  input  logic       sr_exit_req,
  input  logic       clk_stable
);
  localparam int unsigned BL_W = $clog2(BACKLOG_MAX + 1);

  srm_state_e      state;
  srm_op_e         op;
  logic            tick;
  logic            hs;
  logic            bl_nz;
  logic [BL_W-1:0] backlog_cnt;
  logic            sref_taken;
  logic            recover_done;
  logic            in_run;

  assign in_run = (state == ST_RUN);
  assign hs     = cmd_valid && cmd_ready;

  srm_interval_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (in_run),
    .tick (tick)
  );

  srm_backlog #(.MAX(BACKLOG_MAX)) u_backlog (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc       (tick),
    .dec       (hs && in_run),
    .clear     (sref_taken),
    .preset_one(recover_done),
    .count     (backlog_cnt),
    .nonzero   (bl_nz)
  );

  srm_sr_fsm #(.T_RAS(T_RAS), .T_XSR(T_XSR)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .enter_req    (sr_enter_req),
    .exit_req     (sr_exit_req),
    .clk_stable   (clk_stable),
    .backlog_empty(!bl_nz),
    .hs           (hs),
    .state        (state),
    .cke          (cke),
    .sref_taken   (sref_taken),
    .recover_done (recover_done)
  );

  // Offer depends on registered state only, so it holds under back-pressure.
  always_comb begin
    cmd_valid = 1'b0;
    op        = SRM_OP_AREF;
    unique case (state)
      ST_RUN:        cmd_valid = bl_nz;
      ST_SR_ISSUE:   begin cmd_valid = 1'b1; op = SRM_OP_SREF; end
      ST_SR_RECOVER: begin cmd_valid = 1'b1; op = SRM_OP_NOP;  end
      default:       cmd_valid = 1'b0;
    endcase
  end

  assign cmd_op = op;
endmodule

// File: rtl/srm_checker.sv
module srm_checker
  import srm_pkg::*;
#(
  parameter  int unsigned T_RAS       = 5,
  parameter  int unsigned T_XSR       = 8,
  parameter  int unsigned BACKLOG_MAX = 8,
  localparam int unsigned BL_W        = $clog2(BACKLOG_MAX + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic [1:0]      cmd_op,
  input logic            cke,
  input logic            clk_stable,
  input logic [BL_W-1:0] backlog
);
  localparam int unsigned XSR_EFF = (T_XSR < 2) ? 2 : T_XSR;
  localparam int unsigned LOW_LIM = T_RAS + 1;
  localparam int unsigned LW      = $clog2(LOW_LIM + 1);
  localparam int unsigned NW      = $clog2(XSR_EFF + 1);

  logic          cke_q;
  logic [LW-1:0] low_cnt;
  logic [NW-1:0] nop_cnt;
  logic          nop_hs;

  assign nop_hs = cmd_valid && cmd_ready && (cmd_op == SRM_OP_NOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cke_q   <= 1'b1;
      low_cnt <= '0;
      nop_cnt <= NW'(XSR_EFF);
    end else begin
      cke_q <= cke;
      if (cke)                         low_cnt <= '0;
      else if (low_cnt != LW'(LOW_LIM)) low_cnt <= low_cnt + LW'(1);
      if (cke && !cke_q)               nop_cnt <= nop_hs ? NW'(1) : NW'(0);
      else if (nop_hs && nop_cnt != NW'(XSR_EFF)) nop_cnt <= nop_cnt + NW'(1);
    end
  end

  // R4
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op));

  // R6
  sref_cke_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == SRM_OP_SREF |-> !cke);

  // R3
  backlog_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    backlog <= BL_W'(BACKLOG_MAX));

  // R8
  cke_rise_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> $past(clk_stable));

  // R7
  dwell_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> low_cnt >= LW'(LOW_LIM));

  // R10
  catchup_after_nops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == SRM_OP_AREF |-> nop_cnt == NW'(XSR_EFF));

  // R5
  no_sref_with_cke_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> cmd_valid && cmd_op == SRM_OP_SREF);
endmodule

bind sdr_refresh_mgr srm_checker #(
  .T_RAS(T_RAS), .T_XSR(T_XSR), .BACKLOG_MAX(BACKLOG_MAX)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .cke       (cke),
  .clk_stable(clk_stable),
  .backlog   (backlog_cnt)
);

// File: tb/sdr_refresh_mgr_bench.sv
module sdr_refresh_mgr_bench;
  localparam int REF_INT = 40;
  localparam int T_RAS   = 6;
  localparam int T_XSR   = 1;
  localparam int BL_MAX  = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid;
  logic       cmd_ready = 1'b0;
  logic [1:0] cmd_op;
  logic       cke;
  logic       sr_enter_req = 1'b0;
  logic       sr_exit_req = 1'b0;
  logic       clk_stable = 1'b1;

  int checks = 0;
  int errors = 0;
  int edges = 0;
  int nop_hs = 0;
  int aref_hs = 0;
  int sref_hs = 0;

  always #5 clk = ~clk;

  sdr_refresh_mgr #(
    .REF_INTERVAL(REF_INT), .T_RAS(T_RAS), .T_XSR(T_XSR), .BACKLOG_MAX(BL_MAX)
  ) u_sdr_refresh_mgr (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cke(cke), .sr_enter_req(sr_enter_req),
    .sr_exit_req(sr_exit_req), .clk_stable(clk_stable)
  );

  function automatic int exp_ticks(input int n_edges);
    return n_edges / REF_INT;
  endfunction

  function automatic int exp_drain(input int ticks);
    return (ticks > BL_MAX) ? BL_MAX : ticks;
  endfunction

  function automatic int exp_nops();
    return (T_XSR < 2) ? 2 : T_XSR;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Records the handshake of the coming edge, then moves to the next negedge.
  task automatic cyc();
    if (cmd_valid && cmd_ready) begin
      case (cmd_op)
        2'd0: nop_hs++;
        2'd1: aref_hs++;
        2'd2: sref_hs++;
        default: ;
      endcase
    end
    @(negedge clk);
    edges++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int bad;
    int n;
    void'($urandom(32'h5eed_1234));
    repeat (5) @(negedge clk);
    // R1: reset state
    chk("R1 cke", int'(cke), 1);
    chk("R1 cmd_valid", int'(cmd_valid), 0);
    rst_n = 1'b1;

    // R2: first request after REF_INTERVAL edges
    while (edges < REF_INT - 1) cyc();
    chk("R2 no request before interval", int'(cmd_valid), 0);
    cyc();
    chk("R2 request at interval", int'(cmd_valid && cmd_op == 2'd1), 1);

    // R4 / R3: back-pressure until backlog saturates
    bad = 0;
    while (edges < 12 * REF_INT) begin
      cyc();
      if (!(cmd_valid && cmd_op == 2'd1)) bad++;
    end
    chk("R4 held under back-pressure", bad, 0);
    aref_hs = 0;
    cmd_ready = 1'b1;
    repeat (20) cyc();
    chk("R3 saturated drain count", aref_hs, exp_drain(exp_ticks(12 * REF_INT)));

    // R2 / R11: random grants, spurious exit requests in normal operation
    aref_hs = 0;
    bad = 0;
    for (int i = 0; i < 400; i++) begin
      cmd_ready   = (($urandom % 4) == 0);
      sr_exit_req = $urandom % 2;
      cyc();
      if (!cke) bad++;
    end
    sr_exit_req = 1'b0;
    chk("R11 exit ignored in normal mode", bad, 0);
    cmd_ready = 1'b1;
    repeat (10) cyc();
    chk("R2 distributed refresh count", aref_hs, exp_ticks(910) - exp_ticks(500));

    // R5: entry waits behind a pending refresh
    cmd_ready = 1'b0;
    while (edges < 23 * REF_INT) cyc();
    chk("R2 request after idle interval", int'(cmd_valid && cmd_op == 2'd1), 1);
    sr_enter_req = 1'b1;
    bad = 0;
    repeat (5) begin
      cyc();
      if (!(cmd_valid && cmd_op == 2'd1 && cke)) bad++;
    end
    chk("R5 entry waits for backlog", bad, 0);
    cmd_ready = 1'b1;
    cyc();
    cmd_ready = 1'b0;
    cyc();
    // R6: SELF REFRESH offered with CKE low, held under back-pressure
    chk("R6 self refresh offered cke low", int'(cmd_valid && cmd_op == 2'd2 && !cke), 1);
    bad = 0;
    repeat (3) begin
      cyc();
      if (!(cmd_valid && cmd_op == 2'd2 && !cke)) bad++;
    end
    chk("R6 self refresh held", bad, 0);

    // R7: early exit request, dwell still honoured
    cmd_ready    = 1'b1;
    sr_exit_req  = 1'b1;
    clk_stable   = 1'b1;
    sr_enter_req = 1'b0;
    cyc();
    cmd_ready = 1'b0;
    n = 0;
    while (!cke && n < 100) begin
      n++;
      cyc();
    end
    chk("R7 cke low samples after grant", n, T_RAS + 1);
    sr_exit_req = 1'b0;

    // R9: NOP-only recovery counted by grants
    chk("R9 nop offered after cke rise", int'(cmd_valid && cmd_op == 2'd0), 1);
    bad = 0;
    repeat (3) begin
      cyc();
      if (!(cmd_valid && cmd_op == 2'd0)) bad++;
    end
    chk("R9 nop held without grant", bad, 0);
    nop_hs = 0;
    n = 0;
    while (cmd_valid && cmd_op == 2'd0 && n < 200) begin
      cmd_ready = $urandom % 2;
      n++;
      cyc();
    end
    chk("R9 recovery nop count", nop_hs, exp_nops());
    // R10: catch-up refresh right after recovery
    chk("R10 catch-up refresh offered", int'(cmd_valid && cmd_op == 2'd1), 1);
    cmd_ready = 1'b1;
    cyc();
    cmd_ready = 1'b0;
    chk("R10 single catch-up refresh", int'(cmd_valid), 0);

    // R8 / R11: exit blocked while clock unstable, enter ignored in self refresh
    cmd_ready    = 1'b1;
    sr_enter_req = 1'b1;
    cyc();
    chk("R6 second entry offered", int'(cmd_valid && cmd_op == 2'd2 && !cke), 1);
    sref_hs = 0;
    cyc();
    chk("R6 second entry granted", sref_hs, 1);
    sr_exit_req = 1'b1;
    clk_stable  = 1'b0;
    cmd_ready   = 1'b0;
    bad = 0;
    n = 0;
    repeat (30) begin
      cyc();
      if (cke) bad++;
      if (cmd_valid) n++;
    end
    chk("R8 cke held low without stable clock", bad, 0);
    chk("R11 enter ignored in self refresh", n, 0);
    sr_enter_req = 1'b0;
    clk_stable   = 1'b1;
    cyc();
    chk("R8 cke rises once clock stable", int'(cke), 1);
    sr_exit_req = 1'b0;
    nop_hs    = 0;
    cmd_ready = 1'b1;
    repeat (exp_nops()) cyc();
    chk("R9 recovery nops with steady grant", nop_hs, exp_nops());
    chk("R10 catch-up after second exit", int'(cmd_valid && cmd_op == 2'd1), 1);
    aref_hs = 0;
    cyc();
    chk("R3 catch-up consumed by grant", aref_hs, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule